// File: doc/BRIEF.md
# Pipeline PC Resume Keeper

This block travels beside a five-stage in-order pipeline whose state lives in ordinary volatile flip-flops. Every instruction's program counter rides in a per-stage register that moves exactly when the instruction moves. Because of this, the address at which execution must resume after a power loss is always known directly. It never has to be reconstructed by subtracting a fixed offset, which would fail after a taken branch or jump, when the addresses in neighbouring stages are not consecutive.

When the power manager signals an imminent brown-out, the block freezes the pipeline for one cycle so that the instruction in the last stage retires. It then picks the oldest instruction that has not completed. That is the memory-stage entry if it is valid. If the memory stage holds a bubble, it is the oldest valid entry among execute, decode and fetch. If all of those stages are empty, it is the next fetch address. The block writes that address, together with a set valid flag, to a nonvolatile register through a write port with an acknowledge.

When power returns, the block reads the nonvolatile register and pulses a restart strobe with the address fetch must jump to. If the saved flag was clear, that address is the reset vector. If the flag was set, the block also clears the flag before letting the pipeline run.

Top module: `pc_resume_keeper`

## Requirements
- R1: After reset every stage valid bit is 0, and nv_wr_en, nv_rd_en, restart and pipe_run are all 0 until a power-up sequence completes.
- R2: While pipe_run is 1 with no stall and no flush, each stage i>0 takes the PC and valid bit of stage i-1 at the clock edge, and stage 0 takes fetch_pc and fetch_valid; PCs are carried unchanged even when they are not sequential.
- R3: A stall bit set for stage k holds the PC and valid bit of stages 0 to k. Stage k+1, if it exists, receives a bubble, and stages beyond k+1 keep advancing.
- R4: With flush_en high and flush_stg = k (stage numbering 0 = fetch, 1 = decode, 2 = execute, 3 = memory, 4 = writeback), the entries in stages below k are invalidated as they move, and the fetch input of that cycle is discarded. Stage k and older stages move normally.
- R5: power_down seen while running makes pipe_run 0 in that same cycle, so no stage moves. On the next cycle nv_wr_en rises with nv_wr_flag = 1 and nv_wr_pc equal to the PC of the highest-numbered valid stage among 0 to 3, or fetch_pc if none of them is valid.
- R6: A nonvolatile write keeps nv_wr_en, nv_wr_pc and nv_wr_flag steady until nv_wr_ack is seen. After the backup write, pipe_run stays 0 until a restore completes.
- R7: power_down has no effect while the block is powered off or waiting for power; no nonvolatile write is issued.
- R8: power_ok while off or waiting gives a one-cycle nv_rd_en on the next cycle. The read data is sampled one cycle after nv_rd_en, and on the following cycle restart pulses for one cycle with restart_pc = nv_rd_pc if nv_rd_flag was 1, else the reset vector.
- R9: If the read flag was 1, a nonvolatile write with nv_wr_flag = 0 starts in the restart cycle and pipe_run stays 0 until its acknowledge. If the flag was 0, pipe_run is 1 from the restart cycle on.
- R10: All stage valid bits are 0 when restart pulses, so no pre-outage entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | PCW | PC of the instruction being fetched |
| fetch_valid | input | 1 | Fetch slot holds a real instruction |
| stall | input | NSTG | Per-stage stall requests |
| flush_en | input | 1 | Flush request |
| flush_stg | input | $clog2(NSTG) | Stage whose younger entries are flushed |
| stage_pc | output | NSTG*PCW | Per-stage PCs, stage i at bits i*PCW upward |
| stage_vld | output | NSTG | Per-stage valid bits |
| pipe_run | output | 1 | Pipeline may advance this cycle |
| power_down | input | 1 | Brown-out warning |
| power_ok | input | 1 | Supply is good again |
| nv_wr_en | output | 1 | Nonvolatile write request |
| nv_wr_pc | output | PCW | PC to store |
| nv_wr_flag | output | 1 | Valid flag to store |
| nv_wr_ack | input | 1 | Nonvolatile write accepted |
| nv_rd_en | output | 1 | Nonvolatile read request |
| nv_rd_pc | input | PCW | Stored PC, one cycle after nv_rd_en |
| nv_rd_flag | input | 1 | Stored flag, one cycle after nv_rd_en |
| restart | output | 1 | One-cycle restart strobe for fetch |
| restart_pc | output | PCW | Address fetch restarts at |

## Verification
Checked on every cycle: the shift of stage 0 into stage 1 and of the fetch input into stage 0, the hold under a stall at the last stage, the stability of a pending nonvolatile write until its acknowledge, the freeze of the pipeline while a backup write is pending, the single-cycle shape of the read and restart strobes, the cleared flag on a write issued with restart, and the empty pipeline at restart. Only the bench's scenarios can show which PC is chosen for backup:
- the memory-stage entry after a stall and a flush have punched bubbles into the pipe;
- an execute-stage entry when the memory stage is empty;
- the fetch address when the pipe is empty.

They also show the round trip of that address through the nonvolatile register to restart_pc, the reset-vector start on a clear flag, and that power_down is ignored while off.

// File: rtl/prk_pkg.sv
package prk_pkg;

   // Power sequencing states of the resume keeper.
   typedef enum logic [2:0] {
      ST_BOOT   = 3'd0,   // waiting for first power_ok
      ST_RDREQ  = 3'd1,   // nonvolatile read issued
      ST_RDDATA = 3'd2,   // read data present on the port
      ST_CLEAR  = 3'd3,   // clearing the stored valid flag
      ST_RUN    = 3'd4,   // pipeline running
      ST_SAVE   = 3'd5,   // writing the resume PC
      ST_OFF    = 3'd6    // backup done, waiting for power_ok
   } prk_state_t;

   // Index of the oldest stage whose instruction is not yet complete.
   function automatic int unsigned oldest_open_stage(input int unsigned nstg);
      return nstg - 2;
   endfunction

endpackage

// File: rtl/prk_stage_chain.sv
// Per-stage PC and valid registers that move with the instructions.
module prk_stage_chain #(
   parameter int unsigned NSTG = 5,
   parameter int unsigned PCW  = 32,
   localparam int unsigned IDXW = $clog2(NSTG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run,
   input  logic                       clr,
   input  logic [PCW-1:0]             fetch_pc,
   input  logic                       fetch_valid,
   input  logic [NSTG-1:0]            stall,
   input  logic                       flush_en,
   input  logic [IDXW-1:0]            flush_stg,
   output logic [NSTG-1:0][PCW-1:0]   pc_q,
   output logic [NSTG-1:0]            vld_q
);

   logic [NSTG-1:0] hold;
   logic [NSTG-1:0] kill;

   // A stall in stage k freezes every stage from fetch up to k.
   for (genvar i = 0; i < NSTG; i++) begin : g_ctl
      assign hold[i] = |stall[NSTG-1:i];
      assign kill[i] = flush_en && (IDXW'(i) < flush_stg);
   end

   for (genvar i = 0; i < NSTG; i++) begin : g_stg
      logic [PCW-1:0] src_pc;
      logic           src_vld;

      if (i == 0) begin : g_head
         // Fetch input is dropped on a flush.
         assign src_pc  = fetch_pc;
         assign src_vld = fetch_valid & ~flush_en;
      end else begin : g_body
         // Upstream entry: bubble if it is held or flushed.
         assign src_pc  = pc_q[i-1];
         assign src_vld = vld_q[i-1] & ~kill[i-1] & ~hold[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q[i]  <= '0;
            vld_q[i] <= 1'b0;
         end else if (clr) begin
            vld_q[i] <= 1'b0;
         end else if (run) begin
            if (hold[i]) begin
               vld_q[i] <= vld_q[i] & ~kill[i];
            end else begin
               pc_q[i]  <= src_pc;
               vld_q[i] <= src_vld;
            end
         end
      end
   end

endmodule

// File: rtl/prk_resume_pick.sv
// Chooses the oldest incomplete instruction's PC as the resume point.
module prk_resume_pick #(
   parameter int unsigned PCW    = 32,
   parameter int unsigned OLDEST = 3
) (
   input  logic [OLDEST:0][PCW-1:0] pc,
   input  logic [OLDEST:0]          vld,
   input  logic [PCW-1:0]           fetch_pc,
   output logic [PCW-1:0]           resume_pc
);

   // Higher stage index is older; the last match in the scan wins.
   always_comb begin
      resume_pc = fetch_pc;
      for (int i = 0; i <= int'(OLDEST); i++) begin
         if (vld[i]) begin
            resume_pc = pc[i];
         end
      end
   end

endmodule

// File: rtl/prk_power_seq.sv
// Backup and restore sequencing against the nonvolatile PC register.
module prk_power_seq
   import prk_pkg::*;
#(
   parameter int unsigned    PCW       = 32,
   parameter logic [PCW-1:0] RESET_VEC = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           power_down,
   input  logic           power_ok,
   input  logic [PCW-1:0] resume_pc,
   output logic           run,
   output logic           clr,
   output logic           nv_wr_en,
   output logic [PCW-1:0] nv_wr_pc,
   output logic           nv_wr_flag,
   input  logic           nv_wr_ack,
   output logic           nv_rd_en,
   input  logic [PCW-1:0] nv_rd_pc,
   input  logic           nv_rd_flag,
   output logic           restart,
   output logic [PCW-1:0] restart_pc
);

   prk_state_t     st_q, st_d;
   logic [PCW-1:0] save_pc_q;
   logic [PCW-1:0] rs_pc_q;
   logic           rs_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_BOOT,
         ST_OFF:    if (power_ok)   st_d = ST_RDREQ;
         ST_RDREQ:                  st_d = ST_RDDATA;
         ST_RDDATA:                 st_d = nv_rd_flag ? ST_CLEAR : ST_RUN;
         ST_CLEAR:  if (nv_wr_ack)  st_d = ST_RUN;
         ST_RUN:    if (power_down) st_d = ST_SAVE;
         ST_SAVE:   if (nv_wr_ack)  st_d = ST_OFF;
         default:                   st_d = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_BOOT;
         save_pc_q <= '0;
         rs_pc_q   <= RESET_VEC;
         rs_q      <= 1'b0;
      end else begin
         st_q <= st_d;
         rs_q <= 1'b0;
         if (st_q == ST_RUN && power_down) begin
            save_pc_q <= resume_pc;
         end
         if (st_q == ST_RDDATA) begin
            rs_q    <= 1'b1;
            rs_pc_q <= nv_rd_flag ? nv_rd_pc : RESET_VEC;
         end
      end
   end

   // The writeback entry retires in the cycle the pipeline is frozen.
   assign run        = (st_q == ST_RUN) && !power_down;
   assign clr        = (st_q != ST_RUN);
   assign nv_wr_en   = (st_q == ST_SAVE) || (st_q == ST_CLEAR);
   assign nv_wr_flag = (st_q == ST_SAVE);
   assign nv_wr_pc   = (st_q == ST_SAVE) ? save_pc_q : rs_pc_q;
   assign nv_rd_en   = (st_q == ST_RDREQ);
   assign restart    = rs_q;
   assign restart_pc = rs_pc_q;

endmodule

// File: rtl/pc_resume_keeper.sv
// Top: PC shift buffer with nonvolatile resume-point backup.
module pc_resume_keeper
   import prk_pkg::*;
#(
   parameter int unsigned    NSTG      = 5,
   parameter int unsigned    PCW       = 32,
   parameter logic [PCW-1:0] RESET_VEC = PCW'(32'h0000_0100),
   localparam int unsigned   IDXW      = $clog2(NSTG),
   localparam int unsigned   OLDEST    = oldest_open_stage(NSTG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PCW-1:0]       fetch_pc,
   input  logic                 fetch_valid,
   input  logic [NSTG-1:0]      stall,
   input  logic                 flush_en,
   input  logic [IDXW-1:0]      flush_stg,
   output logic [NSTG*PCW-1:0]  stage_pc,
   output logic [NSTG-1:0]      stage_vld,
   output logic                 pipe_run,
   input  logic                 power_down,
   input  logic                 power_ok,
   output logic                 nv_wr_en,
   output logic [PCW-1:0]       nv_wr_pc,
   output logic                 nv_wr_flag,
   input  logic                 nv_wr_ack,
   output logic                 nv_rd_en,
   input  logic [PCW-1:0]       nv_rd_pc,
   input  logic                 nv_rd_flag,
   output logic                 restart,
   output logic [PCW-1:0]       restart_pc
);

   initial begin
      if (NSTG < 3) $error("pc_resume_keeper: NSTG must be at least 3");
      if (PCW < 2)  $error("pc_resume_keeper: PCW must be at least 2");
   end

   logic [NSTG-1:0][PCW-1:0] pc_q;
   logic [NSTG-1:0]          vld_q;
   logic [PCW-1:0]           resume_pc;
   logic                     run;
   logic                     clr;

   prk_stage_chain #(.NSTG(NSTG), .PCW(PCW)) u_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .clr         (clr),
      .fetch_pc    (fetch_pc),
      .fetch_valid (fetch_valid),
      .stall       (stall),
      .flush_en    (flush_en),
      .flush_stg   (flush_stg),
      .pc_q        (pc_q),
      .vld_q       (vld_q)
   );

   prk_resume_pick #(.PCW(PCW), .OLDEST(OLDEST)) u_pick (
      .pc        (pc_q[OLDEST:0]),
      .vld       (vld_q[OLDEST:0]),
      .fetch_pc  (fetch_pc),
      .resume_pc (resume_pc)
   );

   prk_power_seq #(.PCW(PCW), .RESET_VEC(RESET_VEC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_down (power_down),
      .power_ok   (power_ok),
      .resume_pc  (resume_pc),
      .run        (run),
      .clr        (clr),
      .nv_wr_en   (nv_wr_en),
      .nv_wr_pc   (nv_wr_pc),
      .nv_wr_flag (nv_wr_flag),
      .nv_wr_ack  (nv_wr_ack),
      .nv_rd_en   (nv_rd_en),
      .nv_rd_pc   (nv_rd_pc),
      .nv_rd_flag (nv_rd_flag),
      .restart    (restart),
      .restart_pc (restart_pc)
   );

   assign stage_pc  = pc_q;
   assign stage_vld = vld_q;
   assign pipe_run  = run;

endmodule

// File: rtl/prk_checker.sv
// Cycle-level properties of pc_resume_keeper, attached by bind.
module prk_checker #(
   parameter int unsigned NSTG = 5,
   parameter int unsigned PCW  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PCW-1:0]      fetch_pc,
   input logic                fetch_valid,
   input logic [NSTG-1:0]     stall,
   input logic                flush_en,
   input logic                power_down,
   input logic [NSTG*PCW-1:0] stage_pc,
   input logic [NSTG-1:0]     stage_vld,
   input logic                pipe_run,
   input logic                nv_wr_en,
   input logic [PCW-1:0]      nv_wr_pc,
   input logic                nv_wr_flag,
   input logic                nv_wr_ack,
   input logic                nv_rd_en,
   input logic                restart
);

   // R2: stage 0 loads the fetch slot when free to move
   a_r2_fetch_load: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_run && stall == '0 && !flush_en) |=>
      (stage_pc[PCW-1:0] == $past(fetch_pc) && stage_vld[0] == $past(fetch_valid)));

   // R2: stage 1 takes what stage 0 held
   a_r2_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_run && stall == '0 && !flush_en) |=>
      (stage_pc[2*PCW-1:PCW] == $past(stage_pc[PCW-1:0])
       && stage_vld[1] == $past(stage_vld[0])));

   // R3: a stall in the last stage freezes every PC
   a_r3_stall_all: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_run && stall[NSTG-1]) |=> $stable(stage_pc));

   // R5: a backup write never overlaps a moving pipeline
   a_r5_frozen_save: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_wr_en && nv_wr_flag) |-> !pipe_run);

   // R5: a backup write starts only after a power_down warning
   a_r5_save_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(nv_wr_en) && nv_wr_flag) |-> $past(power_down));

   // R6: pending write is held steady until acknowledged
   a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_wr_en && !nv_wr_ack) |=>
      (nv_wr_en && $stable(nv_wr_pc) && $stable(nv_wr_flag)));

   // R8: read request is a single-cycle pulse
   a_r8_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      nv_rd_en |=> !nv_rd_en);

   // R8: restart strobe is a single-cycle pulse
   a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart);

   // R9: a write alongside restart clears the stored flag
   a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && nv_wr_en) |-> !nv_wr_flag);

   // R10: no stale entry survives to restart
   a_r10_empty_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (stage_vld == '0));

endmodule

bind pc_resume_keeper prk_checker #(.NSTG(NSTG), .PCW(PCW)) u_prk_checker (.*);

// File: tb/tb_pc_resume_keeper.sv
module tb_pc_resume_keeper;

   localparam int unsigned NSTG   = 5;
   localparam int unsigned PCW    = 32;
   localparam int unsigned IDXW   = $clog2(NSTG);
   localparam logic [PCW-1:0] RVEC = 32'h0000_0100;
   localparam time CLK_PERIOD     = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [PCW-1:0]       fetch_pc;
   logic                 fetch_valid;
   logic [NSTG-1:0]      stall;
   logic                 flush_en;
   logic [IDXW-1:0]      flush_stg;
   logic [NSTG*PCW-1:0]  stage_pc;
   logic [NSTG-1:0]      stage_vld;
   logic                 pipe_run;
   logic                 power_down;
   logic                 power_ok;
   logic                 nv_wr_en;
   logic [PCW-1:0]       nv_wr_pc;
   logic                 nv_wr_flag;
   logic                 nv_wr_ack;
   logic                 nv_rd_en;
   logic [PCW-1:0]       nv_rd_pc;
   logic                 nv_rd_flag;
   logic                 restart;
   logic [PCW-1:0]       restart_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_resume_keeper #(.NSTG(NSTG), .PCW(PCW), .RESET_VEC(RVEC)) dut (.*);

   // Nonvolatile register model: two-cycle write, one-cycle read.
   logic [PCW-1:0] nv_store_pc;
   logic           nv_store_flag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_wr_ack     <= 1'b0;
         nv_store_pc   <= 32'hDEAD_0000;
         nv_store_flag <= 1'b0;
         nv_rd_pc      <= '0;
         nv_rd_flag    <= 1'b0;
      end else begin
         if (nv_wr_en && !nv_wr_ack) begin
            nv_wr_ack     <= 1'b1;
            nv_store_pc   <= nv_wr_pc;
            nv_store_flag <= nv_wr_flag;
         end else begin
            nv_wr_ack <= 1'b0;
         end
         if (nv_rd_en) begin
            nv_rd_pc   <= nv_store_pc;
            nv_rd_flag <= nv_store_flag;
         end
      end
   end

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic chk(input string req, input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Scoreboard queues filled by the driver, drained by the monitor.
   typedef struct packed {
      logic [PCW-1:0] pc;
      logic           flag;
   } wr_item_t;
   wr_item_t       exp_wr[$];
   logic [PCW-1:0] exp_rs[$];
   wr_item_t       got_wr;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (nv_wr_en && nv_wr_ack) begin
            if (exp_wr.size() == 0) begin
               chk("R6 unexpected nv write", 32'd1, 32'd0);
            end else begin
               got_wr = exp_wr.pop_front();
               chk("R5 nv_wr_pc", nv_wr_pc, got_wr.pc);
               chk("R9 nv_wr_flag", {31'd0, nv_wr_flag}, {31'd0, got_wr.flag});
            end
         end
         if (restart) begin
            if (exp_rs.size() == 0) begin
               chk("R8 unexpected restart", 32'd1, 32'd0);
            end else begin
               chk("R8 restart_pc", restart_pc, exp_rs.pop_front());
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [PCW-1:0] spc(input int idx);
      return stage_pc[idx*PCW +: PCW];
   endfunction

   task automatic chk_stage(input string req, input int idx, input logic v, input logic [PCW-1:0] pc);
      chk({req, " valid"}, {31'd0, stage_vld[idx]}, {31'd0, v});
      if (v) chk({req, " pc"}, spc(idx), pc);
   endtask

   task automatic feed(input logic [PCW-1:0] pc, input logic v);
      fetch_pc    = pc;
      fetch_valid = v;
      step();
   endtask

   // Backup then restore, expecting resume point rpc.
   task automatic power_cycle(input logic [PCW-1:0] rpc);
      exp_wr.push_back('{pc: rpc, flag: 1'b1});
      fetch_valid = 1'b0;
      stall       = '0;
      flush_en    = 1'b0;
      power_down  = 1'b1;
      #1;
      chk("R5 pipe_run frozen", {31'd0, pipe_run}, 32'd0);
      step();
      power_down = 1'b0;
      chk("R5 save starts", {31'd0, nv_wr_en & nv_wr_flag}, 32'd1);
      for (int k = 0; k < 8 && nv_wr_en; k++) step();
      chk("R6 write ends", {31'd0, nv_wr_en}, 32'd0);
      chk("R6 stays stopped", {31'd0, pipe_run}, 32'd0);
      // R7: power_down while off does nothing
      power_down = 1'b1;
      step();
      step();
      power_down = 1'b0;
      chk("R7 no write while off", {31'd0, nv_wr_en}, 32'd0);
      chk("R7 still stopped", {31'd0, pipe_run}, 32'd0);
      exp_rs.push_back(rpc);
      exp_wr.push_back('{pc: rpc, flag: 1'b0});
      power_ok = 1'b1;
      step();
      power_ok = 1'b0;
      chk("R8 read pulse", {31'd0, nv_rd_en}, 32'd1);
      step();
      chk("R8 read single", {31'd0, nv_rd_en}, 32'd0);
      step();
      chk("R8 restart", {31'd0, restart}, 32'd1);
      chk("R10 empty at restart", {27'd0, stage_vld}, 32'd0);
      chk("R9 held for clear", {31'd0, pipe_run}, 32'd0);
      for (int k = 0; k < 8 && !pipe_run; k++) step();
      chk("R9 running after clear", {31'd0, pipe_run}, 32'd1);
   endtask

   logic [PCW-1:0] p [0:6];

   initial begin
      p[0] = 32'h0000_1000; p[1] = 32'h0000_1004; p[2] = 32'h0000_1008;
      p[3] = 32'h0000_2040; p[4] = 32'h0000_2044; p[5] = 32'h0000_2048;
      p[6] = 32'h0000_204C;
      rst_n = 1'b0; fetch_pc = '0; fetch_valid = 1'b0; stall = '0;
      flush_en = 1'b0; flush_stg = '0; power_down = 1'b0; power_ok = 1'b0;
      repeat (3) step();
      // R1: reset state
      chk("R1 stage_vld", {27'd0, stage_vld}, 32'd0);
      chk("R1 nv_wr_en", {31'd0, nv_wr_en}, 32'd0);
      chk("R1 nv_rd_en", {31'd0, nv_rd_en}, 32'd0);
      chk("R1 restart", {31'd0, restart}, 32'd0);
      rst_n = 1'b1;
      step();
      chk("R1 pipe_run", {31'd0, pipe_run}, 32'd0);

      // First power-up: flag clear, so start at the reset vector.
      exp_rs.push_back(RVEC);
      power_ok = 1'b1;
      step();
      power_ok = 1'b0;
      chk("R8 boot read", {31'd0, nv_rd_en}, 32'd1);
      step();
      step();
      chk("R8 boot restart", {31'd0, restart}, 32'd1);
      chk("R9 no clear write", {31'd0, nv_wr_en}, 32'd0);
      chk("R9 runs at once", {31'd0, pipe_run}, 32'd1);

      // R2: fill with a jump between p2 and p3.
      for (int k = 0; k < 5; k++) feed(p[k], 1'b1);
      for (int k = 0; k < 5; k++) chk_stage("R2 fill", k, 1'b1, p[4-k]);

      // R3: stall on execute.
      stall = 5'b00100;
      feed(p[5], 1'b1);
      stall = '0;
      chk_stage("R3 held fetch", 0, 1'b1, p[4]);
      chk_stage("R3 held exec", 2, 1'b1, p[2]);
      chk_stage("R3 bubble mem", 3, 1'b0, '0);
      chk_stage("R3 wb advanced", 4, 1'b1, p[1]);
      feed(p[5], 1'b1);
      chk_stage("R2 after stall", 0, 1'b1, p[5]);
      chk_stage("R2 after stall", 3, 1'b1, p[2]);
      chk_stage("R2 bubble moves", 4, 1'b0, '0);

      // R4: flush behind execute.
      flush_en  = 1'b1;
      flush_stg = 3'd2;
      feed(p[6], 1'b1);
      flush_en  = 1'b0;
      chk_stage("R4 fetch dropped", 0, 1'b0, '0);
      chk_stage("R4 decode killed", 1, 1'b0, '0);
      chk_stage("R4 exec killed", 2, 1'b0, '0);
      chk_stage("R4 mem kept", 3, 1'b1, p[3]);
      chk_stage("R4 wb kept", 4, 1'b1, p[2]);

      // R5: memory stage holds the resume point.
      power_cycle(p[3]);

      // R5: memory stage empty, execute is oldest.
      feed(32'h0000_3000, 1'b1);
      feed(32'h0000_3010, 1'b1);
      feed(32'h0000_3014, 1'b0);
      chk_stage("R2 exec entry", 2, 1'b1, 32'h0000_3000);
      chk_stage("R2 mem bubble", 3, 1'b0, '0);
      power_cycle(32'h0000_3000);

      // R5: empty pipe saves the fetch address.
      fetch_pc = 32'h0000_0ABC;
      power_cycle(32'h0000_0ABC);

      step();
      chk("R8 restart queue drained", exp_rs.size(), 32'd0);
      chk("R6 write queue drained", exp_wr.size(), 32'd0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule